// File: doc/BRIEF.md
# DMA channel address and count sequencer

This block is the transfer engine of a single DMA channel. A register block programs it with a start address, a transfer count, a page value, an auto-reload flag and a width select (byte or 16-bit word). Each completed bus transfer is reported by a one-cycle pulse. On that pulse the block moves its current address forward by one and its remaining count back by one. Throughout, it presents a 24-bit physical address built from the page and the current address.

The programmed count is one less than the number of transfers, so a channel always moves at least one unit. When the count is exhausted, the block pulses terminal count. It then either restarts from the programmed start values (auto-reload) or masks itself and stays idle. The address never carries into the page, so a transfer cannot leave its 64K-byte window (byte mode) or its 128K-byte window (word mode).

The block also reports how much is left to move, in bytes, and it gates the incoming request with the channel mask.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is masked (chan_masked=1), phys_addr=0, cur_count=0, tc=0, residue=1, and xfer_enable=0.
- R2: A cycle with prog_load=1 loads the start address, count, page, auto flag and width into both the start copy and the current state, and clears the mask. The next cycle shows cur_count equal to prog_count.
- R3: In byte mode (prog_word=0), phys_addr[23:16] is the page and phys_addr[15:0] is the current address.
- R4: In word mode (prog_word=1), phys_addr[23:17] is page[7:1] and phys_addr[16:1] is the current address. phys_addr[0] is 0, and page bit 0 has no effect.
- R5: A transfer is accepted when xfer_done=1, the channel is unmasked and prog_load=0. In the next cycle after an accepted transfer with count not 0, the address is one higher and the count one lower. The address wraps from 0xFFFF to 0x0000 and the page does not change.
- R6: tc is high for exactly the one cycle after an accepted transfer that found cur_count=0. A programmed count N therefore yields tc on the (N+1)th accepted transfer.
- R7: Without auto-reload, terminal count leaves cur_count=0xFFFF and the address one higher, and it sets chan_masked=1.
- R8: With auto-reload, terminal count restores the current address and count to the programmed start values, and the mask stays clear.
- R9: While masked, xfer_done pulses change neither the address nor the count, and xfer_enable is 0. When unmasked, xfer_enable follows xfer_req.
- R10: residue is (cur_count+1) modulo 65536 in byte mode and twice that in word mode. It is therefore 0 after a non-reload terminal count.
- R11: mask_wr=1 sets the mask to mask_val and takes precedence over both load and terminal count. Acceptance in that same cycle uses the mask value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_load | input | 1 | Program strobe for start values |
| prog_addr | input | 16 | Start address (bytes or words) |
| prog_count | input | 16 | Transfers minus one |
| prog_page | input | 8 | Page value |
| prog_auto | input | 1 | Auto-reload at terminal count |
| prog_word | input | 1 | 1 = word channel, 0 = byte channel |
| mask_wr | input | 1 | Mask write strobe |
| mask_val | input | 1 | Mask value written |
| xfer_req | input | 1 | Device transfer request |
| xfer_done | input | 1 | One-cycle completed transfer pulse |
| xfer_enable | output | 1 | Request passed on when unmasked |
| phys_addr | output | 24 | Physical address |
| cur_count | output | 16 | Current remaining count minus one |
| residue | output | 17 | Bytes left to move |
| tc | output | 1 | Terminal count pulse |
| chan_masked | output | 1 | Mask state |

## Verification
The assertions assume that xfer_done is a single-cycle pulse sampled on the clock. They also assume that the start values stay unchanged between loads, which holds because they are captured only on prog_load. The stimulus raises prog_load and mask_wr only occasionally against random xfer_done traffic. It programs small counts so that terminal count, auto-reload and self-masking recur often. Directed steps place the address at 0xFFFE so the window wrap is reached, and they collide load and mask writes with transfer pulses.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int CNT_W  = 16;
    localparam int PAGE_W = 8;
    localparam int PHYS_W = CNT_W + PAGE_W;
    localparam int RES_W  = CNT_W + 1;

    typedef enum logic {W_BYTE = 1'b0, W_WORD = 1'b1} width_e;

    typedef struct packed {
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] cnt;
    } cur_t;

    function automatic logic [PHYS_W-1:0] phys_map(
        input logic [PAGE_W-1:0] page,
        input logic [CNT_W-1:0]  addr,
        input width_e            w
    );
        if (w == W_WORD)
            return {page[PAGE_W-1:1], addr, 1'b0};
        return {page, addr};
    endfunction

    function automatic logic [RES_W-1:0] residue_of(
        input logic [CNT_W-1:0] cnt,
        input width_e           w
    );
        logic [CNT_W-1:0] n;
        n = cnt + 1'b1;
        if (w == W_WORD)
            return {n, 1'b0};
        return {1'b0, n};
    endfunction
endpackage

// File: rtl/dma_seq_step.sv
module dma_seq_step
    import dma_seq_pkg::*;
(
    input  cur_t cur,
    input  cur_t base,
    input  logic auto_en,
    output cur_t nxt,
    output logic wrap_hit
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    always_comb begin
        wrap_hit = (cur.cnt == '0);
        nxt.addr = cur.addr + 1'b1;
        nxt.cnt  = cur.cnt - 1'b1;
        if (wrap_hit) begin
            if (auto_en) begin
                nxt = base;
            end else begin
                nxt.cnt = ALL_ONES;
            end
        end
    end
endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_load,
    input  logic [CNT_W-1:0]  prog_addr,
    input  logic [CNT_W-1:0]  prog_count,
    input  logic [PAGE_W-1:0] prog_page,
    input  logic              prog_auto,
    input  logic              prog_word,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              xfer_done,
    input  cur_t              step_cur,
    input  logic              wrap_hit,
    output cur_t              cur_q,
    output cur_t              base_q,
    output logic [PAGE_W-1:0] page_q,
    output width_e            width_q,
    output logic              auto_q,
    output logic              mask_q,
    output logic              tc_q
);
    logic accept;
    assign accept = xfer_done & ~mask_q & ~prog_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            base_q  <= '0;
            page_q  <= '0;
            width_q <= W_BYTE;
            auto_q  <= 1'b0;
            mask_q  <= 1'b1;
            tc_q    <= 1'b0;
        end else begin
            tc_q <= accept & wrap_hit;
            if (prog_load) begin
                base_q  <= '{addr: prog_addr, cnt: prog_count};
                cur_q   <= '{addr: prog_addr, cnt: prog_count};
                page_q  <= prog_page;
                auto_q  <= prog_auto;
                width_q <= prog_word ? W_WORD : W_BYTE;
            end else if (accept) begin
                cur_q <= step_cur;
            end
            if (mask_wr)
                mask_q <= mask_val;
            else if (prog_load)
                mask_q <= 1'b0;
            else if (accept && wrap_hit && !auto_q)
                mask_q <= 1'b1;
        end
    end

    // R9: a masked channel keeps its position
    p_ignore_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (mask_q && xfer_done && !prog_load) |=> $stable(cur_q));

    // R5: ordinary step
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && cur_q.cnt != '0) |=>
        (cur_q.addr == $past(cur_q.addr) + 1'b1) && (cur_q.cnt == $past(cur_q.cnt) - 1'b1));

    // R6: terminal count only follows an accepted transfer at zero
    p_tc_origin_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_q) |-> ($past(cur_q.cnt) == '0 && $past(xfer_done)));

    // R7: stop and self-mask
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && cur_q.cnt == '0 && !auto_q && !mask_wr) |=> (mask_q && tc_q && cur_q.cnt == '1));

    // R8: reload from start copy
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && cur_q.cnt == '0 && auto_q) |=> (cur_q == base_q && tc_q));
endmodule

// File: rtl/dma_seq_map.sv
module dma_seq_map
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] page,
    input  cur_t              cur,
    input  width_e            width,
    output logic [PHYS_W-1:0] phys,
    output logic [RES_W-1:0]  residue
);
    always_comb begin
        phys    = phys_map(page, cur.addr, width);
        residue = residue_of(cur.cnt, width);
    end

    // R10: exhausted count reports nothing left
    p_residue_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (cur.cnt == '1) |-> (residue == '0));

    // R4: word channel address is even and the page low bit is dropped
    p_word_even_r4: assert property (@(posedge clk) disable iff (rst)
        (width == W_WORD) |-> (phys[0] == 1'b0 && phys[CNT_W] == cur.addr[CNT_W-1]));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_load,
    input  logic [CNT_W-1:0]  prog_addr,
    input  logic [CNT_W-1:0]  prog_count,
    input  logic [PAGE_W-1:0] prog_page,
    input  logic              prog_auto,
    input  logic              prog_word,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              xfer_req,
    input  logic              xfer_done,
    output logic              xfer_enable,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic [RES_W-1:0]  residue,
    output logic              tc,
    output logic              chan_masked
);
    cur_t              cur_q, base_q, step_cur;
    logic [PAGE_W-1:0] page_q;
    width_e            width_q;
    logic              auto_q, mask_q, tc_q, wrap_hit;

    dma_seq_step u_step (
        .cur      (cur_q),
        .base     (base_q),
        .auto_en  (auto_q),
        .nxt      (step_cur),
        .wrap_hit (wrap_hit)
    );

    dma_seq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .prog_load  (prog_load),
        .prog_addr  (prog_addr),
        .prog_count (prog_count),
        .prog_page  (prog_page),
        .prog_auto  (prog_auto),
        .prog_word  (prog_word),
        .mask_wr    (mask_wr),
        .mask_val   (mask_val),
        .xfer_done  (xfer_done),
        .step_cur   (step_cur),
        .wrap_hit   (wrap_hit),
        .cur_q      (cur_q),
        .base_q     (base_q),
        .page_q     (page_q),
        .width_q    (width_q),
        .auto_q     (auto_q),
        .mask_q     (mask_q),
        .tc_q       (tc_q)
    );

    dma_seq_map u_map (
        .clk     (clk),
        .rst     (rst),
        .page    (page_q),
        .cur     (cur_q),
        .width   (width_q),
        .phys    (phys_addr),
        .residue (residue)
    );

    assign xfer_enable = xfer_req & ~mask_q;
    assign cur_count   = cur_q.cnt;
    assign tc          = tc_q;
    assign chan_masked = mask_q;

    // R9: no request passes a masked channel
    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        chan_masked |-> !xfer_enable);
endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        prog_load, prog_auto, prog_word, mask_wr, mask_val, xfer_req, xfer_done;
    logic [15:0] prog_addr, prog_count;
    logic [7:0]  prog_page;
    logic        xfer_enable, tc, chan_masked;
    logic [23:0] phys_addr;
    logic [15:0] cur_count;
    logic [16:0] residue;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // bench model state
    logic [15:0] m_ba, m_bc, m_a, m_c;
    logic [7:0]  m_pg;
    logic        m_auto, m_word, m_mask, m_tc;

    always #10 clk = ~clk;

    dma_chan_seq dut (
        .clk(clk), .rst(rst), .prog_load(prog_load), .prog_addr(prog_addr),
        .prog_count(prog_count), .prog_page(prog_page), .prog_auto(prog_auto),
        .prog_word(prog_word), .mask_wr(mask_wr), .mask_val(mask_val),
        .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_enable(xfer_enable),
        .phys_addr(phys_addr), .cur_count(cur_count), .residue(residue),
        .tc(tc), .chan_masked(chan_masked)
    );

    function automatic logic [23:0] exp_phys(logic [7:0] pg, logic [15:0] a, logic w);
        logic [23:0] p;
        if (w) begin
            p = {8'h00, a} << 1;
            p[23:17] = pg[7:1];
        end else begin
            p = {pg, a};
        end
        return p;
    endfunction

    function automatic logic [16:0] exp_res(logic [15:0] c, logic w);
        logic [16:0] n;
        n = {1'b0, c} + 17'd1;
        n[16] = 1'b0;
        return w ? (n * 17'd2) : n;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check_all();
        chk(m_word ? "R4 phys" : "R3 phys", {8'h0, phys_addr}, {8'h0, exp_phys(m_pg, m_a, m_word)});
        chk("R5 count", {16'h0, cur_count}, {16'h0, m_c});
        chk("R6 tc", {31'h0, tc}, {31'h0, m_tc});
        chk("R9 mask", {31'h0, chan_masked}, {31'h0, m_mask});
        chk("R9 enable", {31'h0, xfer_enable}, {31'h0, xfer_req & ~m_mask});
        chk("R10 residue", {15'h0, residue}, {15'h0, exp_res(m_c, m_word)});
    endtask

    // one clock: drive at negedge, update model, sample after the edge
    task automatic cyc(logic ld, logic [15:0] a, logic [15:0] c, logic [7:0] pg,
                       logic au, logic wd, logic mw, logic mv, logic dn);
        logic acc, hit;
        @(negedge clk);
        prog_load = ld; prog_addr = a; prog_count = c; prog_page = pg;
        prog_auto = au; prog_word = wd; mask_wr = mw; mask_val = mv; xfer_done = dn;
        @(posedge clk);
        acc = dn & ~m_mask & ~ld;
        hit = (m_c == 16'h0);
        m_tc = acc & hit;
        if (ld) begin
            m_ba = a; m_bc = c; m_a = a; m_c = c; m_pg = pg; m_auto = au; m_word = wd;
        end else if (acc) begin
            if (hit && m_auto) begin
                m_a = m_ba; m_c = m_bc;
            end else begin
                m_a = m_a + 16'd1; m_c = m_c - 16'd1;
            end
        end
        if (mw) m_mask = mv;
        else if (ld) m_mask = 1'b0;
        else if (acc && hit && !m_auto) m_mask = 1'b1;
        #2;
        check_all();
    endtask

    task automatic done1();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        void'($urandom(32'd24680));
        rst = 1; prog_load = 0; prog_addr = 0; prog_count = 0; prog_page = 0;
        prog_auto = 0; prog_word = 0; mask_wr = 0; mask_val = 0; xfer_req = 1; xfer_done = 0;
        m_ba = 0; m_bc = 0; m_a = 0; m_c = 0; m_pg = 0; m_auto = 0; m_word = 0;
        m_mask = 1; m_tc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #2;
        // R1 reset state
        chk("R1 masked", {31'h0, chan_masked}, 32'd1);
        chk("R1 phys", {8'h0, phys_addr}, 32'd0);
        chk("R1 count", {16'h0, cur_count}, 32'd0);
        chk("R1 tc", {31'h0, tc}, 32'd0);
        chk("R1 residue", {15'h0, residue}, 32'd1);
        chk("R1 enable", {31'h0, xfer_enable}, 32'd0);

        // R2 load, R3 byte map, R5 window wrap
        cyc(1, 16'hFFFE, 16'd2, 8'h3C, 0, 0, 0, 0, 0);
        chk("R2 count", {16'h0, cur_count}, 32'd2);
        chk("R2 unmask", {31'h0, chan_masked}, 32'd0);
        chk("R3 phys", {8'h0, phys_addr}, 32'h3CFFFE);
        done1();
        done1();
        chk("R5 wrap", {8'h0, phys_addr}, 32'h3C0000);
        done1();
        // R7 stop, R6 tc
        chk("R6 tc", {31'h0, tc}, 32'd1);
        chk("R7 count", {16'h0, cur_count}, 32'hFFFF);
        chk("R7 masked", {31'h0, chan_masked}, 32'd1);
        chk("R10 zero", {15'h0, residue}, 32'd0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 one cycle", {31'h0, tc}, 32'd0);
        // R9 ignored while masked
        done1();
        done1();
        chk("R9 hold", {8'h0, phys_addr}, 32'h3C0001);

        // R4 word map, R8 reload, R10 word residue
        cyc(1, 16'h1234, 16'd1, 8'h3D, 1, 1, 0, 0, 0);
        chk("R4 phys", {8'h0, phys_addr}, 32'h3C2468);
        chk("R10 word", {15'h0, residue}, 32'd4);
        done1();
        done1();
        chk("R8 tc", {31'h0, tc}, 32'd1);
        chk("R8 reload", {8'h0, phys_addr}, 32'h3C2468);
        chk("R8 count", {16'h0, cur_count}, 32'd1);
        chk("R8 unmasked", {31'h0, chan_masked}, 32'd0);

        // R11 collisions
        cyc(1, 16'h0100, 16'd5, 8'h01, 0, 0, 0, 0, 1);
        chk("R11 load wins", {16'h0, cur_count}, 32'd5);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 1);
        chk("R11 accept old", {16'h0, cur_count}, 32'd4);
        chk("R11 masked", {31'h0, chan_masked}, 32'd1);
        cyc(1, 16'h0200, 16'd0, 8'h02, 0, 0, 1, 1, 0);
        chk("R11 over load", {31'h0, chan_masked}, 32'd1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 1);
        chk("R11 over tc", {31'h0, chan_masked}, 32'd0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            xfer_req = 1'($urandom);
            if (r < 8'd10)
                cyc(1, 16'($urandom) | ((r[0]) ? 16'hFFF0 : 16'h0), 16'($urandom % 6),
                    8'($urandom), 1'($urandom), 1'($urandom), 0, 0, 1'($urandom));
            else if (r < 8'd14)
                cyc(0, 0, 0, 0, 0, 0, 1, 1'($urandom), 1'($urandom));
            else
                cyc(0, 0, 0, 0, 0, 0, 0, 0, (r[1:0] != 2'b00));
        end
        finish_up();
    end
endmodule